// File: doc/BRIEF.md
# Synchronous PWM Gate Sequencer

This block is the digital core of one current-mode PWM channel. It drives a main switch gate and a complementary synchronous-rectifier gate, and keeps a programmable dead time between them. The analog comparators and the oscillator sit outside. They reach the block as single-cycle-sampled flags: a one-shot clock pulse, a ramp-over-feedback trip, a soft current-limit trip and a hard current-limit trip. A run enable gates everything.

A clock pulse sets the internal demand latch. The ramp trip, either current-limit trip, or the next clock pulse clears it. Clear always wins over set. A hard current-limit trip also arms a skip counter, which keeps the next two clock pulses from setting the latch. The dead-time stage turns the demand into the two gate levels. It takes the active gate down first, waits the programmed number of system clock cycles with both gates low, and then raises the other gate. Both gate outputs are registered.

Top module: `sync_pwm_seq`

## Requirements
- R1: While rst_ni is low, gate_o and gate_b_o are both 0.
- R2: When run_i is sampled low, both gates are 0 after that edge. Any pending skip count is also cleared, so the first clock pulse after run returns can raise the main gate.
- R3: With run high and no demand, gate_b_o settles to 1. A clock pulse sampled at edge k with no skip pending and no clear condition drops gate_b_o after edge k+1 and raises gate_o after edge k+1+max(D,1), where D is dead_cnt_i.
- R4: A ramp_trip_i sampled high at edge k drops gate_o after edge k+1. gate_b_o then rises max(D,1) cycles later.
- R5: An oc_lo_i sampled high ends the cycle with the same timing as R4.
- R6: An oc_hi_i sampled high ends the cycle as in R4. The two clock pulses after it do not set the demand, and the third does.
- R7: A clock pulse that arrives in the same cycle as any clear flag does not set the demand.
- R8: A clock pulse that arrives while the demand is set ends it, with the timing of R4, and does not restart it.
- R9: gate_o and gate_b_o are never 1 together. Between one gate falling and the other rising, both stay low for max(D,1) cycles, so D=0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel run enable |
| clk_pulse_i | input | 1 | One-cycle clock pulse; the only set source |
| ramp_trip_i | input | 1 | Ramp exceeded feedback minus offset |
| oc_lo_i | input | 1 | First current-limit threshold exceeded |
| oc_hi_i | input | 1 | Second, higher current-limit threshold exceeded |
| dead_cnt_i | input | DT_W | Dead time in system clock cycles (0 means 1) |
| gate_o | output | 1 | Main switch gate |
| gate_b_o | output | 1 | Synchronous-rectifier gate |

## Verification
Two kinds of collision matter. A clock pulse can land in the same cycle as a clear flag, and a hard current-limit trip can land on a clock pulse, so that the skip load competes with its decrement. Directed sequences put a pulse and a ramp trip in one cycle, then check that gate_o stays low and gate_b_o stays high over the following cycles. A long random run fires pulses at a fixed period and trips at low rates, so that trips often coincide with pulses. Every cycle's gate pair is compared against a bench model built from the requirements.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic [1:0] {
    GS_DEAD = 2'd0,
    GS_MAIN = 2'd1,
    GS_RECT = 2'd2
  } gate_st_e;
endpackage

// File: rtl/pwm_skip_ctr.sv
module pwm_skip_ctr #(
  parameter int SKIP_N = 2,
  localparam int SW = (SKIP_N < 2) ? 1 : $clog2(SKIP_N + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic arm_i,
  input  logic pulse_i,
  output logic skip_o
);
  localparam logic [SW-1:0] LOAD = SW'(SKIP_N);
  localparam logic [SW-1:0] ONE  = SW'(1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (arm_i)                    cnt_q <= LOAD;   // load wins over decrement
    else if (pulse_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign skip_o = (cnt_q != '0);
endmodule

// File: rtl/pwm_latch.sv
module pwm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;   // clear dominant
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/pwm_dead_time.sv
module pwm_dead_time
  import sync_pwm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            demand_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            gate_o,
  output logic            gate_b_o
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  gate_st_e        st_q;
  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] load;

  // gap of max(D,1) cycles: counter holds remaining cycles minus one
  assign load = (dead_cnt_i == '0) ? '0 : dead_cnt_i - ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= GS_DEAD;
      cnt_q <= '0;
    end else if (!run_i) begin
      st_q  <= GS_DEAD;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        GS_MAIN: if (!demand_i) begin
          st_q  <= GS_DEAD;
          cnt_q <= load;
        end
        GS_RECT: if (demand_i) begin
          st_q  <= GS_DEAD;
          cnt_q <= load;
        end
        default: begin
          if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else             st_q  <= demand_i ? GS_MAIN : GS_RECT;
        end
      endcase
    end
  end

  assign gate_o   = (st_q == GS_MAIN);
  assign gate_b_o = (st_q == GS_RECT);
endmodule

// File: rtl/sync_pwm_seq.sv
module sync_pwm_seq #(
  parameter int DT_W   = 4,
  parameter int SKIP_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clk_pulse_i,
  input  logic            ramp_trip_i,
  input  logic            oc_lo_i,
  input  logic            oc_hi_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            gate_o,
  output logic            gate_b_o
);
  logic demand_q;
  logic skip_act;
  logic set_req;
  logic clr_req;

  generate
    if (SKIP_N > 0) begin : g_skip
      pwm_skip_ctr #(.SKIP_N(SKIP_N)) u_skip (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .arm_i  (oc_hi_i),
        .pulse_i(clk_pulse_i),
        .skip_o (skip_act)
      );
    end else begin : g_noskip
      assign skip_act = 1'b0;
    end
  endgenerate

  // pulse while demand set marks maximum duty
  assign clr_req = !run_i || ramp_trip_i || oc_lo_i || oc_hi_i
                   || (clk_pulse_i && demand_q);
  assign set_req = clk_pulse_i && !skip_act;

  pwm_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_req),
    .clr_i (clr_req),
    .q_o   (demand_q)
  );

  pwm_dead_time #(.DT_W(DT_W)) u_dead (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .demand_i  (demand_q),
    .dead_cnt_i(dead_cnt_i),
    .gate_o    (gate_o),
    .gate_b_o  (gate_b_o)
  );
endmodule

// File: rtl/sync_pwm_seq_chk.sv
module sync_pwm_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic ramp_trip_i,
  input logic oc_lo_i,
  input logic oc_hi_i,
  input logic gate_o,
  input logic gate_b_o
);
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o && gate_b_o));

  a_r9_main_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> !$past(gate_b_o));

  a_r9_rect_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_b_o) |-> !$past(gate_o));

  a_r2_run_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!gate_o && !gate_b_o));

  a_r4_ramp_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_trip_i |=> ##1 !gate_o);

  a_r5_oc_lo_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_lo_i |=> ##1 !gate_o);

  a_r6_oc_hi_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_hi_i |=> ##1 !gate_o);
endmodule

bind sync_pwm_seq sync_pwm_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .ramp_trip_i(ramp_trip_i),
  .oc_lo_i    (oc_lo_i),
  .oc_hi_i    (oc_hi_i),
  .gate_o     (gate_o),
  .gate_b_o   (gate_b_o)
);

// File: tb/sync_pwm_seq_tb.sv
module sync_pwm_seq_tb;
  localparam int DT_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            run = 1'b1;
  logic            pulse = 1'b0;
  logic            ramp = 1'b0;
  logic            oc_lo = 1'b0;
  logic            oc_hi = 1'b0;
  logic [DT_W-1:0] dead = 4'd3;
  logic            gate;
  logic            gate_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_pwm_seq #(.DT_W(DT_W), .SKIP_N(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .clk_pulse_i(pulse),
    .ramp_trip_i(ramp),
    .oc_lo_i    (oc_lo),
    .oc_hi_i    (oc_hi),
    .dead_cnt_i (dead),
    .gate_o     (gate),
    .gate_b_o   (gate_b)
  );

  // reference model from the requirements
  logic m_dem, m_g, m_gb;
  int   m_skip, m_cnt;

  function automatic int gap_of(input logic [DT_W-1:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dem = 0; m_g = 0; m_gb = 0; m_skip = 0; m_cnt = 0;
    end else begin
      automatic logic od = m_dem;
      automatic logic nd = m_dem;
      automatic int   ns = m_skip;
      if (!run || ramp || oc_lo || oc_hi || (pulse && m_dem)) nd = 0;
      else if (pulse && m_skip == 0) nd = 1;
      if (!run) ns = 0;
      else if (oc_hi) ns = 2;
      else if (pulse && m_skip > 0) ns = m_skip - 1;
      if (!run) begin
        m_g = 0; m_gb = 0; m_cnt = 0;
      end else if (m_g && !od) begin
        m_g = 0; m_cnt = gap_of(dead) - 1;
      end else if (m_gb && od) begin
        m_gb = 0; m_cnt = gap_of(dead) - 1;
      end else if (!m_g && !m_gb) begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        else if (od) m_g = 1;
        else m_gb = 1;
      end
      m_dem = nd; m_skip = ns;
    end
  end

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_once();
    pulse = 1; step(1); pulse = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5106));
    step(3);
    check(gate, 0, "R1", "gate in reset");
    check(gate_b, 0, "R1", "gate_b in reset");
    rst_n = 1;
    step(3);
    check(gate_b, 1, "R3", "idle rectifier on");

    // R3: set by pulse, D=3
    pulse_once();
    step(1); check(gate_b, 0, "R3", "rect drops");
    step(2); check(gate, 0, "R9", "still in gap");
    step(1); check(gate, 1, "R3", "main rises after gap");

    // R4: ramp trip
    ramp = 1; step(1); ramp = 0;
    step(1); check(gate, 0, "R4", "main drops");
    step(2); check(gate_b, 0, "R4", "rect in gap");
    step(1); check(gate_b, 1, "R4", "rect rises");

    // R5: soft limit
    pulse_once(); step(5); check(gate, 1, "R5", "precondition main on");
    oc_lo = 1; step(1); oc_lo = 0;
    step(1); check(gate, 0, "R5", "main drops");
    step(3); check(gate_b, 1, "R5", "rect rises");

    // R6: hard limit and two skipped pulses
    pulse_once(); step(5); check(gate, 1, "R6", "precondition main on");
    oc_hi = 1; step(1); oc_hi = 0;
    step(1); check(gate, 0, "R6", "main drops");
    step(4);
    pulse_once(); step(8); check(gate, 0, "R6", "first pulse skipped");
    pulse_once(); step(8); check(gate, 0, "R6", "second pulse skipped");
    pulse_once(); step(4); check(gate, 1, "R6", "third pulse sets");

    // R8: pulse while demand set ends it without restart
    pulse_once();
    step(1); check(gate, 0, "R8", "max duty end");
    step(8); check(gate, 0, "R8", "no restart");
    check(gate_b, 1, "R8", "rect on");

    // R7: set and clear in one cycle
    pulse = 1; ramp = 1; step(1); pulse = 0; ramp = 0;
    step(8); check(gate, 0, "R7", "clear dominates");
    check(gate_b, 1, "R7", "rect stays");

    // R2: run low, then skip cleared by run low
    pulse_once(); step(5); check(gate, 1, "R2", "precondition main on");
    run = 0; step(1);
    check(gate, 0, "R2", "main off");
    check(gate_b, 0, "R2", "rect off");
    run = 1; step(3);
    oc_hi = 1; step(1); oc_hi = 0;
    run = 0; step(2); run = 1; step(3);
    pulse_once(); step(4); check(gate, 1, "R2", "skip cleared");

    // R9: D=0 acts as 1
    dead = 0;
    ramp = 1; step(1); ramp = 0;
    step(1); check(gate, 0, "R9", "main off D0");
    check(gate_b, 0, "R9", "one cycle gap D0");
    step(1); check(gate_b, 1, "R9", "rect on after one cycle");

    // random phase against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      check(gate, m_g, "R3", "random main");
      check(gate_b, m_gb, "R9", "random rect");
      if (gate && gate_b) check(1'b1, 1'b0, "R9", "overlap");
      if (cyc % 50 == 0) dead = DT_W'($urandom_range(0, 5));
      pulse = (cyc % 12 == 0);
      ramp  = ($urandom_range(0, 9) == 0);
      oc_lo = ($urandom_range(0, 39) == 0);
      oc_hi = ($urandom_range(0, 79) == 0);
      run   = ($urandom_range(0, 199) != 0);
      step(1);
    end
    pulse = 0; ramp = 0; oc_lo = 0; oc_hi = 0; run = 1;
    step(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule